// File: doc/BRIEF.md
# Masked fault latch and flag logic

This block sits between the analog fault sensors of a two-channel line driver and its register bank. Every cycle it takes the raw fault indications (for each channel: short to supply, short to ground, current limit, excessive offset and open load; for the whole device: thermal warning, thermal shutdown and overvoltage). It gates each one with its mask bit and with the global diagnostic enable, and holds the result in three sticky status registers. The bus block reads these registers, and a read clears a bit only when the condition behind it has gone.

From the held bits the block drives an active-low open-drain fault flag, modelled as an output enable that pulls the line low while asserted. It also assembles a live status byte that shows the flag, which channel outputs are switched to high impedance, the latched offset faults and a device identifier. It also resolves the pin-over-register overrides: the shutdown pin can force the device off, and the mute pin can force mute on. The register contents and the read strobes come from the bus block. The serial protocol and the analog sensing are outside this block.

Top module: `fault_status_core`

## Requirements
- R1: After a synchronous active-low reset all three fault registers read 0x00, `flag_oe` is 0 and `flag_byte` equals `{5'b0, DEV_ID}` (0x04 with the default identifier 3'b100).
- R2: A raw fault is recorded only when config bit 7 (diagnostic enable) is 1 and its mask bit is 1. Channel registers and masks place short to supply at bit 7, short to ground at bit 6, current limit at bit 5, offset at bit 3 and open load at bit 2. The general register and mask place thermal warning at bit 6, thermal shutdown at bit 5 and overvoltage at bit 4. Raw channel inputs are `{supply, ground, limit, offset, open}` as bits 4..0, and raw general inputs are `{twarn, tshdn, overvoltage}` as bits 2..0.
- R3: A qualified fault appears in its register one clock after it is sampled. The bit stays set after the raw input drops for as long as no read strobe for that register arrives.
- R4: A read strobe clears, on the next clock, each bit of that register whose qualified condition is absent in the read cycle. A bit whose condition is still present stays set.
- R5: An offset fault is recorded only while the effective mute is active.
- R6: `flag_oe` is 1 exactly when any bit of any fault register is set, and `flag_byte` bit 7 mirrors `flag_oe`.
- R7: `flag_byte` bit 6 (left) and bit 5 (right) report that a channel output is high impedance. This holds when that channel has a latched short to supply or to ground, or when thermal shutdown is latched. A current-limit fault alone does not set them.
- R8: `flag_byte` bits 4 and 3 show the latched left and right offset faults, and bits 2..0 carry `DEV_ID`.
- R9: `eff_enable` is config bit 6 AND `shdn_pin_n`, so a low shutdown pin overrides the enable bit.
- R10: `eff_mute` is config bit 5 OR NOT `mute_pin_n`, so a low mute pin forces mute.
- R11: A read strobe for one register leaves the other two registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte | input | 8 | Config register: bit 7 diagnostic enable, bit 6 enable, bit 5 mute |
| gen_mask | input | 8 | General fault mask (bits 6, 5, 4) |
| left_mask | input | 8 | Left channel fault mask (bits 7, 6, 5, 3, 2) |
| right_mask | input | 8 | Right channel fault mask (bits 7, 6, 5, 3, 2) |
| gen_raw | input | 3 | Raw thermal warning, thermal shutdown, overvoltage (bits 2..0) |
| left_raw | input | 5 | Raw left supply short, ground short, limit, offset, open (bits 4..0) |
| right_raw | input | 5 | Raw right channel faults, same order as the left |
| shdn_pin_n | input | 1 | Shutdown pin, low forces the device off |
| mute_pin_n | input | 1 | Mute pin, low forces mute |
| rd_gen | input | 1 | Read strobe for the general fault register |
| rd_left | input | 1 | Read strobe for the left fault register |
| rd_right | input | 1 | Read strobe for the right fault register |
| gen_fault | output | 8 | Latched general faults |
| left_fault | output | 8 | Latched left channel faults |
| right_fault | output | 8 | Latched right channel faults |
| flag_byte | output | 8 | Live status byte |
| flag_oe | output | 1 | Pull-down enable of the open-drain fault flag |
| eff_enable | output | 1 | Enable after the pin override |
| eff_mute | output | 1 | Mute after the pin override |

## Verification
A read strobe and a change in a raw fault can land on the same clock edge, and the result then depends on how clearing and setting combine. The bench provokes this in two ways. First, it strobes a read while the original condition is still active, and expects the bit to survive. Second, it strobes a read of a register holding a stale short-to-supply bit in the same cycle that a fresh current-limit fault first appears, and expects the stale bit to be gone and the new one to be held. Both results are judged from the register value sampled one clock after the strobe.

// File: rtl/fsc_pkg.sv
// Shared constants of the fault status core: register widths, the bit
// positions a neighbouring bus block decodes, and the raw input order.
// Assumes one clock domain and eight-bit registers.
package fsc_pkg;
    localparam int REG_W      = 8;
    localparam int CH_RAW_W   = 5;
    localparam int GEN_RAW_W  = 3;
    localparam int ID_W       = 3;
    localparam int NUM_CH     = 2;

    // config register fields
    localparam int CFG_DIAG   = 7;
    localparam int CFG_EN     = 6;
    localparam int CFG_MUTE   = 5;

    // channel fault register and mask positions
    localparam int BIT_SUPPLY = 7;
    localparam int BIT_GROUND = 6;
    localparam int BIT_LIMIT  = 5;
    localparam int BIT_OFFSET = 3;
    localparam int BIT_OPEN   = 2;

    // general fault register and mask positions
    localparam int BIT_TWARN  = 6;
    localparam int BIT_TSHDN  = 5;
    localparam int BIT_OVP    = 4;

    // raw channel input order
    localparam int RAW_SUPPLY = 4;
    localparam int RAW_GROUND = 3;
    localparam int RAW_LIMIT  = 2;
    localparam int RAW_OFFSET = 1;
    localparam int RAW_OPEN   = 0;

    // raw general input order
    localparam int RAW_TWARN  = 2;
    localparam int RAW_TSHDN  = 1;
    localparam int RAW_OVP    = 0;

    // status byte fields
    localparam int FLG_ANY    = 7;
    localparam int FLG_LHIZ   = 6;
    localparam int FLG_RHIZ   = 5;
    localparam int FLG_LOFF   = 4;
    localparam int FLG_ROFF   = 3;
endpackage

// File: rtl/fsc_latch_bank.sv
// Sticky clear-on-read register of W bits. A bit sets whenever its qualified
// condition is high and clears on a read strobe only while the condition is
// low. Assumes the read strobe is one cycle wide per bus read.
module fsc_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    input  logic         rd,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic bit_q;
        // hold or set one status bit; read drops it unless still active
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= cond[b] | (bit_q & ~rd);
        end
        assign q[b] = bit_q;
    end
endmodule

// File: rtl/fsc_chan_gate.sv
// Qualifies the raw faults of one channel with its mask and the global
// diagnostic enable, placing them at their register positions. The offset
// check is only valid while the outputs are muted.
module fsc_chan_gate
    import fsc_pkg::*;
(
    input  logic [CH_RAW_W-1:0] raw,
    input  logic [REG_W-1:0]    mask,
    input  logic                diag_en,
    input  logic                mute_now,
    output logic [REG_W-1:0]    cond
);
    logic unused_mask_bits;
    assign unused_mask_bits = ^{mask[4], mask[1:0]};

    // map each raw indication onto its register bit
    always_comb begin
        cond             = '0;
        cond[BIT_SUPPLY] = raw[RAW_SUPPLY] & mask[BIT_SUPPLY] & diag_en;
        cond[BIT_GROUND] = raw[RAW_GROUND] & mask[BIT_GROUND] & diag_en;
        cond[BIT_LIMIT]  = raw[RAW_LIMIT]  & mask[BIT_LIMIT]  & diag_en;
        cond[BIT_OFFSET] = raw[RAW_OFFSET] & mask[BIT_OFFSET] & diag_en & mute_now;
        cond[BIT_OPEN]   = raw[RAW_OPEN]   & mask[BIT_OPEN]   & diag_en;
    end
endmodule

// File: rtl/fsc_status.sv
// Builds the live status byte, the open-drain flag enable and the
// pin-over-register overrides. Purely combinational from latched faults,
// config bits and the two control pins.
module fsc_status
    import fsc_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 3'b100
) (
    input  logic [REG_W-1:0] cfg_byte,
    input  logic [REG_W-1:0] gen_q,
    input  logic [REG_W-1:0] left_q,
    input  logic [REG_W-1:0] right_q,
    input  logic             shdn_pin_n,
    input  logic             mute_pin_n,
    output logic [REG_W-1:0] flag_byte,
    output logic             flag_oe,
    output logic             eff_enable,
    output logic             eff_mute
);
    logic any_fault;
    logic left_hiz;
    logic right_hiz;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_byte[CFG_DIAG], cfg_byte[4:0]};

    // channel switched off by a short or by thermal shutdown
    always_comb begin
        left_hiz  = left_q[BIT_SUPPLY]  | left_q[BIT_GROUND]  | gen_q[BIT_TSHDN];
        right_hiz = right_q[BIT_SUPPLY] | right_q[BIT_GROUND] | gen_q[BIT_TSHDN];
        any_fault = (|gen_q) | (|left_q) | (|right_q);
    end

    // assemble the status byte
    always_comb begin
        flag_byte           = '0;
        flag_byte[FLG_ANY]  = any_fault;
        flag_byte[FLG_LHIZ] = left_hiz;
        flag_byte[FLG_RHIZ] = right_hiz;
        flag_byte[FLG_LOFF] = left_q[BIT_OFFSET];
        flag_byte[FLG_ROFF] = right_q[BIT_OFFSET];
        flag_byte[ID_W-1:0] = DEV_ID;
    end

    // open-drain pull-down and pin overrides
    always_comb begin
        flag_oe    = any_fault;
        eff_enable = cfg_byte[CFG_EN] & shdn_pin_n;
        eff_mute   = cfg_byte[CFG_MUTE] | ~mute_pin_n;
    end
endmodule

// File: rtl/fault_status_core.sv
// Top of the fault status core: qualifies raw faults, latches them into the
// general, left and right clear-on-read registers and drives the fault flag
// and live status. Assumes inputs are synchronous to clk.
module fault_status_core
    import fsc_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 3'b100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_W-1:0]     cfg_byte,
    input  logic [REG_W-1:0]     gen_mask,
    input  logic [REG_W-1:0]     left_mask,
    input  logic [REG_W-1:0]     right_mask,
    input  logic [GEN_RAW_W-1:0] gen_raw,
    input  logic [CH_RAW_W-1:0]  left_raw,
    input  logic [CH_RAW_W-1:0]  right_raw,
    input  logic                 shdn_pin_n,
    input  logic                 mute_pin_n,
    input  logic                 rd_gen,
    input  logic                 rd_left,
    input  logic                 rd_right,
    output logic [REG_W-1:0]     gen_fault,
    output logic [REG_W-1:0]     left_fault,
    output logic [REG_W-1:0]     right_fault,
    output logic [REG_W-1:0]     flag_byte,
    output logic                 flag_oe,
    output logic                 eff_enable,
    output logic                 eff_mute
);
    logic                diag_en;
    logic [REG_W-1:0]    gen_cond;
    logic [REG_W-1:0]    ch_q    [NUM_CH];
    logic [REG_W-1:0]    ch_mask [NUM_CH];
    logic [CH_RAW_W-1:0] ch_raw  [NUM_CH];
    logic                ch_rd   [NUM_CH];
    logic                unused_gmask_bits;

    assign diag_en           = cfg_byte[CFG_DIAG];
    assign unused_gmask_bits = ^{gen_mask[7], gen_mask[3:0]};

    // gather per-channel inputs into arrays
    always_comb begin
        ch_raw[0]  = left_raw;
        ch_raw[1]  = right_raw;
        ch_mask[0] = left_mask;
        ch_mask[1] = right_mask;
        ch_rd[0]   = rd_left;
        ch_rd[1]   = rd_right;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [REG_W-1:0] cond;
        fsc_chan_gate u_gate (
            .raw      (ch_raw[c]),
            .mask     (ch_mask[c]),
            .diag_en  (diag_en),
            .mute_now (eff_mute),
            .cond     (cond)
        );
        fsc_latch_bank #(.W(REG_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (cond),
            .rd    (ch_rd[c]),
            .q     (ch_q[c])
        );
    end

    // qualify device-wide faults
    always_comb begin
        gen_cond            = '0;
        gen_cond[BIT_TWARN] = gen_raw[RAW_TWARN] & gen_mask[BIT_TWARN] & diag_en;
        gen_cond[BIT_TSHDN] = gen_raw[RAW_TSHDN] & gen_mask[BIT_TSHDN] & diag_en;
        gen_cond[BIT_OVP]   = gen_raw[RAW_OVP]   & gen_mask[BIT_OVP]   & diag_en;
    end

    fsc_latch_bank #(.W(REG_W)) u_gen_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (gen_cond),
        .rd    (rd_gen),
        .q     (gen_fault)
    );

    assign left_fault  = ch_q[0];
    assign right_fault = ch_q[1];

    fsc_status #(.DEV_ID(DEV_ID)) u_status (
        .cfg_byte   (cfg_byte),
        .gen_q      (gen_fault),
        .left_q     (left_fault),
        .right_q    (right_fault),
        .shdn_pin_n (shdn_pin_n),
        .mute_pin_n (mute_pin_n),
        .flag_byte  (flag_byte),
        .flag_oe    (flag_oe),
        .eff_enable (eff_enable),
        .eff_mute   (eff_mute)
    );
endmodule

// File: rtl/fsc_checker.sv
// Temporal checks on the fault status core, attached by bind. Observes
// ports only; left channel short-to-supply and offset stand for the others.
module fsc_checker
    import fsc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [REG_W-1:0]    cfg_byte,
    input logic [REG_W-1:0]    left_mask,
    input logic [CH_RAW_W-1:0] left_raw,
    input logic                rd_left,
    input logic [REG_W-1:0]    gen_fault,
    input logic [REG_W-1:0]    left_fault,
    input logic [REG_W-1:0]    right_fault,
    input logic [REG_W-1:0]    flag_byte,
    input logic                flag_oe,
    input logic                eff_enable,
    input logic                eff_mute,
    input logic                shdn_pin_n
);
    // R2: a masked or disabled fault never sets a clear bit
    p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(left_fault[BIT_SUPPLY]) &&
         !($past(cfg_byte[CFG_DIAG]) && $past(left_mask[BIT_SUPPLY])))
        |-> !left_fault[BIT_SUPPLY]);

    // R3: a set bit survives while no read arrives
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (left_fault[BIT_SUPPLY] && !rd_left) |=> left_fault[BIT_SUPPLY]);

    // R4: read with the condition gone clears the bit
    p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_left && !left_raw[RAW_SUPPLY]) |=> !left_fault[BIT_SUPPLY]);

    // R5: no offset capture while unmuted
    p_offset_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(left_fault[BIT_OFFSET]) && !$past(eff_mute))
        |-> !left_fault[BIT_OFFSET]);

    // R6: any latched fault pulls the flag
    p_flag_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen_fault != '0) || (left_fault != '0) || (right_fault != '0))
        |-> (flag_oe && flag_byte[FLG_ANY]));

    // R7: current limit alone leaves the left output driven
    p_limit_no_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (left_fault[BIT_LIMIT] && !left_fault[BIT_SUPPLY] &&
         !left_fault[BIT_GROUND] && !gen_fault[BIT_TSHDN])
        |-> !flag_byte[FLG_LHIZ]);

    // R9: low shutdown pin wins over the enable bit
    p_shdn_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_pin_n |-> !eff_enable);
endmodule

bind fault_status_core fsc_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_byte    (cfg_byte),
    .left_mask   (left_mask),
    .left_raw    (left_raw),
    .rd_left     (rd_left),
    .gen_fault   (gen_fault),
    .left_fault  (left_fault),
    .right_fault (right_fault),
    .flag_byte   (flag_byte),
    .flag_oe     (flag_oe),
    .eff_enable  (eff_enable),
    .eff_mute    (eff_mute),
    .shdn_pin_n  (shdn_pin_n)
);

// File: tb/fault_status_core_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module fault_status_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_byte, gen_mask, left_mask, right_mask;
    logic [2:0] gen_raw;
    logic [4:0] left_raw, right_raw;
    logic       shdn_pin_n, mute_pin_n, rd_gen, rd_left, rd_right;
    logic [7:0] gen_fault, left_fault, right_fault, flag_byte;
    logic       flag_oe, eff_enable, eff_mute;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fault_status_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .gen_mask(gen_mask),
        .left_mask(left_mask), .right_mask(right_mask), .gen_raw(gen_raw),
        .left_raw(left_raw), .right_raw(right_raw), .shdn_pin_n(shdn_pin_n),
        .mute_pin_n(mute_pin_n), .rd_gen(rd_gen), .rd_left(rd_left),
        .rd_right(rd_right), .gen_fault(gen_fault), .left_fault(left_fault),
        .right_fault(right_fault), .flag_byte(flag_byte), .flag_oe(flag_oe),
        .eff_enable(eff_enable), .eff_mute(eff_mute)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock edge, inputs driven and outputs sampled at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        left_raw = '0; right_raw = '0; gen_raw = '0;
        rd_gen = 1; rd_left = 1; rd_right = 1;
        tick();
        rd_gen = 0; rd_left = 0; rd_right = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; cfg_byte = 8'h80; gen_mask = 8'hff; left_mask = 8'hff;
        right_mask = 8'hff; gen_raw = '0; left_raw = '0; right_raw = '0;
        shdn_pin_n = 1; mute_pin_n = 1; rd_gen = 0; rd_left = 0; rd_right = 0;
        tick(); tick();
        check("R1 gen", gen_fault, 8'h00);
        check("R1 left", left_fault, 8'h00);
        check("R1 right", right_fault, 8'h00);
        check("R1 flag_oe", {7'b0, flag_oe}, 8'h00);
        check("R1 flag_byte", flag_byte, 8'h04);
        rst_n = 1;
        tick();
    endtask

    task automatic t_gate();
        cfg_byte = 8'h00; left_raw = 5'h1d;
        tick();
        check("R2 diag off", left_fault, 8'h00);
        cfg_byte = 8'h80; left_mask = 8'h00;
        tick();
        check("R2 mask off", left_fault, 8'h00);
        left_mask = 8'h80;
        tick();
        check("R2 one mask bit", left_fault, 8'h80);
        left_mask = 8'hff; gen_raw = 3'b101;
        tick();
        check("R2 general twarn+ovp", gen_fault, 8'h50);
        clear_all();
        check("R2 cleared", left_fault | gen_fault, 8'h00);
    endtask

    task automatic t_sticky();
        left_raw = 5'h10;
        tick();
        check("R3 set", left_fault, 8'h80);
        left_raw = '0;
        tick(); tick();
        check("R3 sticky", left_fault, 8'h80);
    endtask

    task automatic t_read();
        left_raw = 5'h10; rd_left = 1;
        tick();
        rd_left = 0;
        check("R4 read while active", left_fault, 8'h80);
        left_raw = '0; rd_left = 1;
        tick();
        rd_left = 0;
        check("R4 read cleared", left_fault, 8'h00);
    endtask

    task automatic t_offset();
        cfg_byte = 8'h80; mute_pin_n = 1; left_raw = 5'h02;
        tick();
        check("R5 unmuted ignored", left_fault, 8'h00);
        cfg_byte = 8'ha0;
        tick();
        check("R5 muted by bit", left_fault, 8'h08);
        clear_all();
        cfg_byte = 8'h80; mute_pin_n = 0; left_raw = 5'h02;
        tick();
        check("R5 R10 muted by pin", left_fault, 8'h08);
        clear_all();
        mute_pin_n = 1;
    endtask

    task automatic t_flag();
        cfg_byte = 8'ha0; right_raw = 5'h02;
        tick();
        check("R6 right offset", right_fault, 8'h08);
        check("R6 flag_oe", {7'b0, flag_oe}, 8'h01);
        check("R8 flag_byte", flag_byte, 8'h8c);
        clear_all();
        check("R6 flag released", {7'b0, flag_oe}, 8'h00);
        cfg_byte = 8'h80;
    endtask

    task automatic t_hiz();
        left_raw = 5'h04;
        tick();
        check("R7 limit only", flag_byte, 8'h84);
        right_raw = 5'h08;
        tick();
        check("R7 right ground", right_fault, 8'h40);
        check("R7 right hiz", flag_byte, 8'ha4);
        clear_all();
        gen_raw = 3'b010;
        tick();
        check("R7 tshdn", gen_fault, 8'h20);
        check("R7 both hiz", flag_byte, 8'he4);
        clear_all();
    endtask

    task automatic t_override();
        cfg_byte = 8'h40; shdn_pin_n = 1; #1;
        check("R9 enabled", {7'b0, eff_enable}, 8'h01);
        shdn_pin_n = 0; #1;
        check("R9 pin wins", {7'b0, eff_enable}, 8'h00);
        cfg_byte = 8'h00; shdn_pin_n = 1; #1;
        check("R9 bit off", {7'b0, eff_enable}, 8'h00);
        mute_pin_n = 1; #1;
        check("R10 unmuted", {7'b0, eff_mute}, 8'h00);
        mute_pin_n = 0; #1;
        check("R10 pin mute", {7'b0, eff_mute}, 8'h01);
        cfg_byte = 8'h20; mute_pin_n = 1; #1;
        check("R10 bit mute", {7'b0, eff_mute}, 8'h01);
        cfg_byte = 8'h80;
        tick();
    endtask

    task automatic t_isolation();
        left_raw = 5'h10; right_raw = 5'h10; gen_raw = 3'b100;
        tick();
        left_raw = '0; right_raw = '0; gen_raw = '0; rd_left = 1;
        tick();
        rd_left = 0;
        check("R11 left read", left_fault, 8'h00);
        check("R11 right kept", right_fault, 8'h80);
        check("R11 gen kept", gen_fault, 8'h40);
        clear_all();
    endtask

    task automatic t_collision();
        left_raw = 5'h10;
        tick();
        left_raw = 5'h04; rd_left = 1;
        tick();
        rd_left = 0;
        check("R4 read meets new fault", left_fault, 8'h20);
        clear_all();
        check("R4 collision cleared", left_fault, 8'h00);
    endtask

    initial begin
        t_reset();
        t_gate();
        t_sticky();
        t_read();
        t_offset();
        t_flag();
        t_hiz();
        t_override();
        t_isolation();
        t_collision();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule